// File: doc/BRIEF.md
# Bit-Level Serial ROM Responder

This block models the slave side of a two-wire serial memory that can only be read. A host produces the bus by writing clock and data levels one at a time. Each write arrives as a single-cycle update strobe carrying the new SCL and SDA levels. On every update the block compares the new pair with the pair it stored last time. From that comparison it finds start and stop conditions and rising clock edges. It clocks in a command byte and then an address byte, forces acknowledge bits, and, when the command asks for a read, puts stored bytes on the data line.

The memory is 256 bytes of 8 bits, held in a parameter image; nothing writes into it. At the end of each address phase, the byte at the received address is latched into a data register. That byte is shifted out during the address phase of the next transaction whose command has its lowest bit set. The block drives the last level it stored, so a forced acknowledge or read bit stays visible until the next update.

Top module: `i2c_rom_slave`

## Requirements
- R1: After reset, sda_out is 1. Both stored levels are 1, and the bit counter, command, address, data register and pending acknowledge are 0.
- R2: An update where SCL is high in both the stored and the new levels and SDA falls is a start. It clears the command and makes the next counted rising edge the first command bit, even in the middle of a transaction. SDA rising with SCL high (a stop) changes no counter.
- R3: While the bit counter is 0 and no acknowledge is pending, every update other than a start only stores the new levels. Clock edges do not count, and no acknowledge is ever forced.
- R4: A data bit is taken only on an SCL rising edge whose SDA level equals the stored SDA level. A rising edge that also changes SDA is discarded and does not advance the counter.
- R5: Command bits are taken most significant bit first. On the rising edge after the eighth counted command bit, sda_out is 0 whatever level the host drives, and the pending acknowledge clears.
- R6: Eight address bits follow, most significant bit first. The next rising edge gives a forced 0 acknowledge. After it the block waits for a new start as in R3.
- R7: When bit 0 of the received command is 1, each of the eight address-bit rising edges sets sda_out to the data register's bit 7, and the data register then shifts left. The data register holds the byte latched at the end of the previous address phase (0 after reset).
- R8: The default memory image holds the byte (29*a + 91) mod 256 at address a, for a from 0 to 255.
- R9: sda_out always equals the last level the block stored. After an update that forces nothing, that is the host's SDA level.
- R10: While bus_upd is low, no state changes, whatever scl_lvl and sda_lvl do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_upd | input | 1 | Update strobe: the levels below are a new bus state |
| scl_lvl | input | 1 | New clock-line level from the host |
| sda_lvl | input | 1 | New data-line level from the host |
| sda_out | output | 1 | Data-line level as seen by the host |

## Verification
The hardest situation to reach is read data appearing on the bus. The byte that comes out is the one latched by the transaction before, so the stimulus chains transactions: each read's address sets up the byte the following read must show. A discarded rising edge is provoked on purpose inside a command byte, by changing SDA in the same update as the clock rise. The test then checks that the acknowledge still lands on the ninth counted edge. Clock toggles with the strobe held low are placed right after a start, where any counted edge would visibly move the acknowledge.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

    localparam int IMG_DEPTH = 256;
    localparam int IMG_W     = 8;

    // classification of one host update against the stored levels
    typedef struct packed {
        logic cond;    // SDA moved while SCL stayed high
        logic start;   // condition with SDA falling
        logic rise;    // SCL low -> high
        logic steady;  // SDA equal to stored level
    } line_ev_t;

    function automatic logic [IMG_DEPTH*IMG_W-1:0] default_image();
        logic [IMG_DEPTH*IMG_W-1:0] v;
        v = '0;
        for (int a = 0; a < IMG_DEPTH; a++) begin
            v[a*IMG_W +: IMG_W] = IMG_W'((a * 29 + 91) % 256);
        end
        return v;
    endfunction

endpackage

// File: rtl/i2cr_line_events.sv
module i2cr_line_events
    import i2cr_pkg::*;
(
    input  logic     scl_prev,
    input  logic     sda_prev,
    input  logic     scl_now,
    input  logic     sda_now,
    output line_ev_t ev
);
    logic cond;

    always_comb begin
        cond      = scl_prev & scl_now & (sda_prev ^ sda_now);
        ev.cond   = cond;
        ev.start  = cond & ~sda_now;
        ev.rise   = ~scl_prev & scl_now;
        ev.steady = ~(sda_prev ^ sda_now);
    end
endmodule

// File: rtl/i2cr_rom.sv
module i2cr_rom #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [(1<<ADDR_W)*DATA_W-1:0] IMAGE = '0
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        rdata = IMAGE[int'(addr)*DATA_W +: DATA_W];
    end
endmodule

// File: rtl/i2c_rom_slave.sv
module i2c_rom_slave
    import i2cr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter logic [(1<<ADDR_W)*DATA_W-1:0] IMAGE = i2cr_pkg::default_image()
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_upd,
    input  logic scl_lvl,
    input  logic sda_lvl,
    output logic sda_out
);
    // tick 1..DATA_W: command bits; CMD_END..ADDR_END-1: address bits
    localparam int CMD_END  = 1 + DATA_W;
    localparam int ADDR_END = CMD_END + ADDR_W;
    localparam int TICK_W   = $clog2(ADDR_END + 1);
    localparam logic [TICK_W-1:0] T_CMD  = TICK_W'(CMD_END);
    localparam logic [TICK_W-1:0] T_ADDR = TICK_W'(ADDR_END);
    localparam logic [TICK_W-1:0] T_ONE  = TICK_W'(1);

    typedef struct packed {
        logic              scl;
        logic              sda;
        logic              ack;
        logic [TICK_W-1:0] tick;
        logic [DATA_W-1:0] cmd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } state_t;

    state_t            st_q, st_d;
    line_ev_t          ev;
    logic [ADDR_W-1:0] addr_shift;
    logic [DATA_W-1:0] rom_byte;
    logic [TICK_W-1:0] tick_inc;

    i2cr_line_events u_ev (
        .scl_prev (st_q.scl),
        .sda_prev (st_q.sda),
        .scl_now  (scl_lvl),
        .sda_now  (sda_lvl),
        .ev       (ev)
    );

    assign addr_shift = {st_q.addr[ADDR_W-2:0], sda_lvl};
    assign tick_inc   = st_q.tick + T_ONE;

    i2cr_rom #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .IMAGE  (IMAGE)
    ) u_rom (
        .addr  (addr_shift),
        .rdata (rom_byte)
    );

    always_comb begin
        st_d = st_q;
        if (bus_upd) begin
            st_d.scl = scl_lvl;
            st_d.sda = sda_lvl;
            if (ev.cond) begin
                if (ev.start) begin
                    st_d.tick = T_ONE;
                    st_d.cmd  = '0;
                end
            end else if (st_q.tick == '0 && !st_q.ack) begin
                // idle: wait for a start
            end else if (ev.rise) begin
                if (st_q.ack) begin
                    st_d.sda = 1'b0;
                    st_d.ack = 1'b0;
                end else if (ev.steady) begin
                    if (st_q.tick < T_CMD) begin
                        st_d.cmd  = {st_q.cmd[DATA_W-2:0], sda_lvl};
                        st_d.tick = tick_inc;
                        if (tick_inc == T_CMD) begin
                            st_d.ack = 1'b1;
                        end
                    end else begin
                        if (st_q.cmd[0]) begin
                            st_d.sda = st_q.data[DATA_W-1];
                        end
                        st_d.addr = addr_shift;
                        st_d.data = {st_q.data[DATA_W-2:0], 1'b0};
                        st_d.tick = tick_inc;
                        if (tick_inc == T_ADDR) begin
                            st_d.data = rom_byte;
                            st_d.ack  = 1'b1;
                            st_d.tick = '0;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.scl  <= 1'b1;
            st_q.sda  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_out = st_q.sda;

endmodule

// File: rtl/i2cr_chk.sv
module i2cr_chk #(
    parameter int TICK_W   = 5,
    parameter int TICK_MAX = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_upd,
    input logic              scl_lvl,
    input logic              sda_lvl,
    input logic              sda_out,
    input logic              scl_q,
    input logic              sda_q,
    input logic              ack_q,
    input logic [TICK_W-1:0] tick_q
);
    // R2
    start_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_upd && scl_q && scl_lvl && sda_q && !sda_lvl |=> tick_q == TICK_W'(1));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_upd && tick_q == '0 && !ack_q && !(scl_q && scl_lvl && sda_q && !sda_lvl)
        |=> tick_q == '0 && !ack_q);

    // R4
    glitch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_upd && !ack_q && tick_q != '0 && !scl_q && scl_lvl && (sda_q != sda_lvl)
        |=> $stable(tick_q));

    // R5
    ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_upd && ack_q && !scl_q && scl_lvl |=> !sda_out && !ack_q);

    // R6
    tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q <= TICK_W'(TICK_MAX));

    // R10
    no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_upd |=> $stable(tick_q) && $stable(sda_out) && $stable(ack_q));
endmodule

bind i2c_rom_slave i2cr_chk #(
    .TICK_W   (TICK_W),
    .TICK_MAX (ADDR_END - 1)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_upd (bus_upd),
    .scl_lvl (scl_lvl),
    .sda_lvl (sda_lvl),
    .sda_out (sda_out),
    .scl_q   (st_q.scl),
    .sda_q   (st_q.sda),
    .ack_q   (st_q.ack),
    .tick_q  (st_q.tick)
);

// File: tb/i2c_rom_slave_test.sv
module i2c_rom_slave_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_upd = 1'b0;
    logic scl_lvl = 1'b1;
    logic sda_lvl = 1'b1;
    logic sda_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit last_sda = 1'b1;
    bit done = 1'b0;

    typedef struct { logic exp; string tag; } item_t;
    item_t exp_q[$];

    always #10 clk = ~clk;

    i2c_rom_slave uut (
        .clk(clk), .rst_n(rst_n), .bus_upd(bus_upd),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .sda_out(sda_out)
    );

    function automatic logic [7:0] mref(int a);
        return 8'((a * 29 + 91) % 256);   // R8 image
    endfunction

    task automatic check(logic act, logic exp, string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: sda_out actual %b expected %b", tag, act, exp);
        end
    endtask

    // monitor: pops one expected level per accepted update
    always @(posedge clk) begin
        if (bus_upd) begin
            #4;
            if (exp_q.size() == 0) begin
                n_tests++; n_fail++;
                $display("FAIL scoreboard: no expectation, actual %b expected none", sda_out);
            end else begin
                item_t it;
                it = exp_q.pop_front();
                check(sda_out, it.exp, it.tag);
            end
        end
    end

    task automatic step(logic s, logic d, logic e, string tag);
        @(negedge clk);
        bus_upd = 1'b1; scl_lvl = s; sda_lvl = d;
        exp_q.push_back('{e, tag});
        last_sda = e;
        @(negedge clk);
        bus_upd = 1'b0;
    endtask

    task automatic do_start(string tag);
        if (last_sda != 1'b1) step(1'b1, 1'b1, 1'b1, tag);  // stop-like, no effect
        step(1'b1, 1'b0, 1'b0, tag);
    endtask

    task automatic clk_bit(logic b, logic e_rise, string tag);
        step(1'b0, b, b, tag);
        step(1'b1, b, e_rise, tag);
    endtask

    task automatic send_byte(logic [7:0] v, bit rd, logic [7:0] dv, string tag);
        for (int i = 7; i >= 0; i--) clk_bit(v[i], rd ? dv[i] : v[i], tag);
    endtask

    task automatic ack_clk(string tag);
        clk_bit(1'b1, 1'b0, tag);   // host releases, block forces 0
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(sda_out, 1'b1, "R1 reset level");

        // R3: clocking before any start is ignored
        send_byte(8'hA0, 1'b0, 8'h00, "R3 pre-start");
        clk_bit(1'b1, 1'b1, "R3 ninth edge pre-start");

        // write-type command, address 0x37: latches mref(0x37)
        do_start("R2 start");
        send_byte(8'hA0, 1'b0, 8'h00, "R5 cmd bits R9");
        ack_clk("R5 cmd ack R9");
        send_byte(8'h37, 1'b0, 8'h00, "R6 addr bits");
        ack_clk("R6 addr ack");

        // R6 / R3: after the address ack the block waits for start
        send_byte(8'hFF, 1'b0, 8'h00, "R6 post-frame idle");
        clk_bit(1'b1, 1'b1, "R3 post-frame ninth edge");

        // read: shows mref(0x37), latches mref(0x00)
        do_start("R2 start");
        send_byte(8'hA1, 1'b0, 8'h00, "R5 cmd bits");
        ack_clk("R5 cmd ack");
        send_byte(8'h00, 1'b1, mref(8'h37), "R7 R8 read 0x37");
        ack_clk("R6 addr ack");

        // R4: a discarded edge inside the command byte
        do_start("R2 start");
        clk_bit(1'b1, 1'b1, "R4 cmd bit");
        clk_bit(1'b0, 1'b0, "R4 cmd bit");
        clk_bit(1'b1, 1'b1, "R4 cmd bit");
        step(1'b0, 1'b0, 1'b0, "R4 low phase");
        step(1'b1, 1'b1, 1'b1, "R4 changed-sda rise");
        clk_bit(1'b0, 1'b0, "R4 cmd bit");
        clk_bit(1'b0, 1'b0, "R4 cmd bit");
        clk_bit(1'b0, 1'b0, "R4 cmd bit");
        clk_bit(1'b0, 1'b0, "R4 cmd bit");
        clk_bit(1'b1, 1'b1, "R4 cmd bit");
        ack_clk("R4 ack after 8 counted bits");
        send_byte(8'hFF, 1'b1, mref(8'h00), "R7 R8 read 0x00");
        ack_clk("R6 addr ack");

        // R2: restart in the middle of a command
        do_start("R2 start");
        clk_bit(1'b1, 1'b1, "R2 partial");
        clk_bit(1'b1, 1'b1, "R2 partial");
        clk_bit(1'b0, 1'b0, "R2 partial");
        do_start("R2 restart");
        send_byte(8'hA1, 1'b0, 8'h00, "R2 cmd after restart");
        ack_clk("R2 ack after restart");
        send_byte(8'h80, 1'b1, mref(8'hFF), "R7 R8 read 0xFF");
        ack_clk("R6 addr ack");

        // R10: toggles without strobe right after a start
        do_start("R10 start");
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); scl_lvl = 1'b0; sda_lvl = 1'b1;
            @(negedge clk); scl_lvl = 1'b1;
        end
        @(negedge clk);
        check(sda_out, 1'b0, "R10 no change without strobe");
        send_byte(8'hA1, 1'b0, 8'h00, "R10 cmd bits");
        ack_clk("R10 ack on ninth counted edge");
        send_byte(8'h5A, 1'b1, mref(8'h80), "R7 R8 read 0x80");
        ack_clk("R6 addr ack");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_tests++; n_fail++;
            $display("FAIL scoreboard: %0d left, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: run not finished, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule